// File: doc/BRIEF.md
# DPLL mode and lock controller

This controller chooses the operating mode of a digital phase-locked loop and drives its lock status. In Normal (tracking) mode the loop follows the selected reference in both frequency and phase. In FreeRun mode the oscillator runs open-loop, and its accuracy is that of the 25 MHz master source. Two inputs can put the loop in FreeRun:

- a failure flag from the reference monitor, raised on a single-cycle or coarse-frequency fault;
- a user select input.

The lock status qualifies on time. A stream of phase-error magnitudes arrives from the phase detector. The lock output rises only after the loop has spent a set span in Normal mode with no out-of-window sample.

When a reference failure pushes the loop into FreeRun, the lock output is held for a hold span of 0.1 s, which is 2,500,000 master-clock cycles. The lock output falls only if the failure outlasts that span. If the reference recovers within the span, the loop returns to Normal with the lock output kept high. A deliberate choice of FreeRun clears the lock output at once.

The phase-error stream uses valid/ready. The controller never applies back-pressure: `pe_ready_o` is tied high, and one sample is consumed on every clock edge where `pe_valid_i` is high. The mode and lock pins are plain level outputs.

Top module: `dpll_mode_lock_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `mode_o` is 1 (FreeRun) and `lock_o` is 0.
- R2: `mode_o` stays 1 while `ref_fail_i` or `sel_free_i` is high. On the edge after both are seen low in FreeRun, `mode_o` becomes 0 (Normal).
- R3: With no out-of-window sample, `lock_o` rises exactly QUAL_CYCLES cycles after `mode_o` turns 0. A sample is inside the window when `pe_mag_i <= WIN_LIMIT`, so the limit value itself counts as inside.
- R4: In Normal mode, with neither `ref_fail_i` nor `sel_free_i` high, an accepted sample with `pe_mag_i > WIN_LIMIT` drives `lock_o` to 0 on the next cycle. It also restarts qualification, so `lock_o` rises again QUAL_CYCLES cycles after that edge.
- R5: `pe_ready_o` is always 1. A magnitude presented with `pe_valid_i` low has no effect on `lock_o`.
- R6: In Normal mode with `sel_free_i` low, a high `ref_fail_i` sets `mode_o` to 1 on the next cycle, and `lock_o` keeps its value.
- R7: If the failure persists, `lock_o` falls exactly HOLD_CYCLES cycles after `mode_o` went to 1. Phase samples during the hold span do not affect `lock_o`.
- R8: If `ref_fail_i` clears within the hold span, `mode_o` returns to 0 on the next cycle and `lock_o` stays high. This holds past the point where the hold span would have ended.
- R9: A high `sel_free_i` sets `mode_o` to 1 and `lock_o` to 0 on the next cycle. This applies in Normal mode and during the hold span.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 25 MHz master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_fail_i | input | 1 | Reference monitor failure request (single-cycle or coarse-frequency) |
| sel_free_i | input | 1 | User selection of FreeRun mode |
| pe_valid_i | input | 1 | Phase-error sample valid |
| pe_ready_o | output | 1 | Phase-error sample ready, always 1 |
| pe_mag_i | input | PE_W | Phase-error magnitude |
| mode_o | output | 1 | 0 = Normal, 1 = FreeRun |
| lock_o | output | 1 | Lock status |

## Verification
The hardest situation to reach is a reference that recovers while the lock is being held. Reaching it takes three steps in order:

1. Qualify the lock fully.
2. Raise the failure flag.
3. Drop the flag again before the hold span ends.

The bench shortens both timers through parameters, so this sequence fits in a few hundred cycles. It then keeps running past the point where the hold span would have expired, to show that the lock output is not dropped late. The same shortened timers let the bench also cover an expiring hold with out-of-window samples injected during it, and a deliberate FreeRun selection made in the middle of a hold.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

  typedef enum logic [1:0] {
    ST_FREE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_HOLD  = 2'd2
  } dlc_state_e;

  localparam logic MODE_TRACK = 1'b0;
  localparam logic MODE_FREE  = 1'b1;

  function automatic logic mode_of(dlc_state_e s);
    return (s == ST_TRACK) ? MODE_TRACK : MODE_FREE;
  endfunction

endpackage

// File: rtl/dlc_window_check.sv
module dlc_window_check #(
  parameter int unsigned PE_W      = 16,
  parameter int unsigned WIN_LIMIT = 1000
) (
  input  logic            valid_i,
  input  logic [PE_W-1:0] mag_i,
  output logic            bad_o
);

  localparam logic [PE_W-1:0] WIN_V = PE_W'(WIN_LIMIT);

  generate
    if (WIN_LIMIT >= (2 ** PE_W) - 1) begin : g_always_inside
      // every representable magnitude falls inside the window
      assign bad_o = 1'b0;
    end else begin : g_compare
      assign bad_o = valid_i && (mag_i > WIN_V);
    end
  endgenerate

endmodule

// File: rtl/dlc_span_timer.sv
module dlc_span_timer #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  output logic done_o
);

  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // counts cycles of uninterrupted run; saturates on the final count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || clear_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = run_i && !clear_i && (cnt_q == LAST);

endmodule

// File: rtl/dlc_mode_fsm.sv
module dlc_mode_fsm
  import dlc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_fail_i,
  input  logic       sel_free_i,
  input  logic       bad_i,
  input  logic       qual_done_i,
  input  logic       hold_done_i,
  output dlc_state_e state_o,
  output logic       lock_o
);

  dlc_state_e state_q, state_d;
  logic       lock_q, lock_d;

  always_comb begin
    state_d = state_q;
    lock_d  = lock_q;
    unique case (state_q)
      ST_FREE: begin
        lock_d = 1'b0;
        if (!ref_fail_i && !sel_free_i) state_d = ST_TRACK;
      end
      ST_TRACK: begin
        if (sel_free_i) begin
          // deliberate choice: no hold interval
          state_d = ST_FREE;
          lock_d  = 1'b0;
        end else if (ref_fail_i) begin
          // failure-induced: lock level carried into the hold span
          state_d = ST_HOLD;
        end else if (bad_i) begin
          lock_d = 1'b0;
        end else if (qual_done_i) begin
          lock_d = 1'b1;
        end
      end
      ST_HOLD: begin
        if (sel_free_i) begin
          state_d = ST_FREE;
          lock_d  = 1'b0;
        end else if (!ref_fail_i) begin
          state_d = ST_TRACK;
        end else if (hold_done_i) begin
          state_d = ST_FREE;
          lock_d  = 1'b0;
        end
      end
      default: begin
        state_d = ST_FREE;
        lock_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FREE;
      lock_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lock_q  <= lock_d;
    end
  end

  assign state_o = state_q;
  assign lock_o  = lock_q;

endmodule

// File: rtl/dpll_mode_lock_ctrl.sv
module dpll_mode_lock_ctrl
  import dlc_pkg::*;
#(
  parameter int unsigned PE_W        = 16,
  parameter int unsigned WIN_LIMIT   = 1000,
  parameter int unsigned HOLD_CYCLES = 2_500_000,
  parameter int unsigned QUAL_CYCLES = 25_000_000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_fail_i,
  input  logic            sel_free_i,
  input  logic            pe_valid_i,
  output logic            pe_ready_o,
  input  logic [PE_W-1:0] pe_mag_i,
  output logic            mode_o,
  output logic            lock_o
);

  dlc_state_e state;
  logic       bad, qual_done, hold_done;

  // the sample stream is consumed every cycle, never stalled
  assign pe_ready_o = 1'b1;

  dlc_window_check #(
    .PE_W      (PE_W),
    .WIN_LIMIT (WIN_LIMIT)
  ) u_win (
    .valid_i (pe_valid_i),
    .mag_i   (pe_mag_i),
    .bad_o   (bad)
  );

  dlc_span_timer #(
    .LIMIT (QUAL_CYCLES)
  ) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state == ST_TRACK),
    .clear_i (bad),
    .done_o  (qual_done)
  );

  dlc_span_timer #(
    .LIMIT (HOLD_CYCLES)
  ) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state == ST_HOLD),
    .clear_i (1'b0),
    .done_o  (hold_done)
  );

  dlc_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_fail_i  (ref_fail_i),
    .sel_free_i  (sel_free_i),
    .bad_i       (bad),
    .qual_done_i (qual_done),
    .hold_done_i (hold_done),
    .state_o     (state),
    .lock_o      (lock_o)
  );

  assign mode_o = mode_of(state);

endmodule

// File: rtl/dlc_checker.sv
module dlc_checker #(
  parameter int unsigned PE_W        = 16,
  parameter int unsigned WIN_LIMIT   = 1000,
  parameter int unsigned HOLD_CYCLES = 2_500_000
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            ref_fail_i,
  input logic            sel_free_i,
  input logic            pe_valid_i,
  input logic [PE_W-1:0] pe_mag_i,
  input logic            mode_o,
  input logic            lock_o
);

  localparam int unsigned HW = $clog2(HOLD_CYCLES + 2);
  localparam logic [PE_W-1:0] WIN_V = PE_W'(WIN_LIMIT);

  logic [HW-1:0] held_cnt;

  // length of the current run of FreeRun mode with lock still high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               held_cnt <= '0;
    else if (mode_o && lock_o) held_cnt <= held_cnt + 1'b1;
    else                       held_cnt <= '0;
  end

  assert_stay_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o && (ref_fail_i || sel_free_i)) |=> mode_o);

  assert_lock_rise_track_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> !mode_o);

  assert_bad_sample_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_o && !ref_fail_i && !sel_free_i && pe_valid_i && (pe_mag_i > WIN_V)) |=> !lock_o);

  assert_fail_keeps_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_o && ref_fail_i && !sel_free_i) |=> (mode_o && (lock_o == $past(lock_o))));

  assert_hold_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_cnt <= HW'(HOLD_CYCLES));

  assert_select_free_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_free_i |=> (mode_o && !lock_o));

endmodule

bind dpll_mode_lock_ctrl dlc_checker #(
  .PE_W        (PE_W),
  .WIN_LIMIT   (WIN_LIMIT),
  .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ref_fail_i (ref_fail_i),
  .sel_free_i (sel_free_i),
  .pe_valid_i (pe_valid_i),
  .pe_mag_i   (pe_mag_i),
  .mode_o     (mode_o),
  .lock_o     (lock_o)
);

// File: tb/dpll_mode_lock_ctrl_tb.sv
module dpll_mode_lock_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PE_W = 10;
  localparam int WIN  = 100;
  localparam int HOLD = 20;
  localparam int QUAL = 30;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_fail = 1'b1;
  logic sel_free = 1'b0;
  logic pe_valid = 1'b0;
  logic [PE_W-1:0] pe_mag = '0;
  logic pe_ready, mode, lock;

  dpll_mode_lock_ctrl #(
    .PE_W        (PE_W),
    .WIN_LIMIT   (WIN),
    .HOLD_CYCLES (HOLD),
    .QUAL_CYCLES (QUAL)
  ) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ref_fail_i (ref_fail),
    .sel_free_i (sel_free),
    .pe_valid_i (pe_valid),
    .pe_ready_o (pe_ready),
    .pe_mag_i   (pe_mag),
    .mode_o     (mode),
    .lock_o     (lock)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    logic  m;
    logic  l;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int n_chk = 0;
  int n_fail = 0;

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // driver side: schedule an expected (mode, lock) pair for a cycle
  task automatic expect_at(int due, logic m, logic l, string tag);
    exp_t e;
    e.due = due;
    e.m   = m;
    e.l   = l;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  // monitor: compares outputs against due items, away from the rising edge
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      n_chk++;
      if (e.due < cyc || mode !== e.m || lock !== e.l) begin
        n_fail++;
        $display("FAIL %s at cycle %0d: mode=%0b lock=%0b, expected mode=%0b lock=%0b",
                 e.tag, cyc, mode, lock, e.m, e.l);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == WATCHDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      report();
    end
  end

  // kind 0: mixed in-window stream with gaps, 1: out of window,
  // 2: exactly the window limit, 3: no valid samples (huge magnitude)
  task automatic run(int n, int kind);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (kind)
        0: begin
          pe_valid = (cyc % 5) != 0;
          pe_mag   = pe_valid ? PE_W'((cyc * 13) % (WIN + 1)) : '1;
        end
        1: begin
          pe_valid = 1'b1;
          pe_mag   = PE_W'(WIN + 1 + (cyc % 7));
        end
        2: begin
          pe_valid = 1'b1;
          pe_mag   = PE_W'(WIN);
        end
        default: begin
          pe_valid = 1'b0;
          pe_mag   = '1;
        end
      endcase
    end
  endtask

  initial begin
    int c;
    run(3, 3);
    expect_at(cyc + 1, 1'b1, 1'b0, "R1 reset state");
    run(2, 3);
    rst_n = 1'b1;
    c = cyc;
    expect_at(c + 1, 1'b1, 1'b0, "R1 first cycle after reset");
    expect_at(c + 5, 1'b1, 1'b0, "R2 stays FreeRun while reference failed");
    run(6, 0);

    sel_free = 1'b1;
    ref_fail = 1'b0;
    c = cyc;
    expect_at(c + 4, 1'b1, 1'b0, "R2 stays FreeRun while selected");
    run(5, 0);

    sel_free = 1'b0;
    c = cyc;
    expect_at(c + 1, 1'b0, 1'b0, "R2 enters Normal");
    expect_at(c + QUAL, 1'b0, 1'b0, "R3 not yet qualified");
    expect_at(c + QUAL + 1, 1'b0, 1'b1, "R3 lock qualified");
    run(QUAL + 3, 0);

    if (pe_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R5 ready: pe_ready=%0b expected 1", pe_ready);
    end
    n_chk++;

    run(1, 1);
    c = cyc;
    expect_at(c + 1, 1'b0, 1'b0, "R4 out-of-window sample drops lock");
    expect_at(c + QUAL, 1'b0, 1'b0, "R4 requalification pending");
    expect_at(c + QUAL + 1, 1'b0, 1'b1, "R4 R3 relock with limit-valued samples");
    run(QUAL + 3, 2);

    c = cyc;
    expect_at(c + 10, 1'b0, 1'b1, "R5 samples without valid ignored");
    run(11, 3);

    ref_fail = 1'b1;
    c = cyc;
    expect_at(c + 1, 1'b1, 1'b1, "R6 failure keeps lock");
    expect_at(c + HOLD, 1'b1, 1'b1, "R7 lock held to end of hold span");
    expect_at(c + HOLD + 1, 1'b1, 1'b0, "R7 lock drops after hold span");
    run(HOLD + 4, 1);

    ref_fail = 1'b0;
    c = cyc;
    expect_at(c + 1, 1'b0, 1'b0, "R2 back to Normal after recovery");
    expect_at(c + QUAL + 1, 1'b0, 1'b1, "R3 relock after recovery");
    run(QUAL + 3, 0);

    ref_fail = 1'b1;
    c = cyc;
    expect_at(c + 1, 1'b1, 1'b1, "R6 failure keeps lock (short)");
    run(4, 0);
    ref_fail = 1'b0;
    c = cyc;
    expect_at(c + 1, 1'b0, 1'b1, "R8 recovered within hold, lock kept");
    expect_at(c + HOLD + 5, 1'b0, 1'b1, "R8 lock still high past hold span");
    run(HOLD + 7, 0);

    sel_free = 1'b1;
    c = cyc;
    expect_at(c + 1, 1'b1, 1'b0, "R9 deliberate FreeRun drops lock at once");
    run(4, 0);
    sel_free = 1'b0;
    c = cyc;
    expect_at(c + QUAL + 1, 1'b0, 1'b1, "R3 relock after deselect");
    run(QUAL + 3, 0);

    ref_fail = 1'b1;
    c = cyc;
    expect_at(c + 1, 1'b1, 1'b1, "R6 failure before select");
    run(3, 0);
    sel_free = 1'b1;
    c = cyc;
    expect_at(c + 1, 1'b1, 1'b0, "R9 select during hold drops lock");
    run(3, 0);

    sel_free = 1'b0;
    ref_fail = 1'b0;
    run(3, 0);
    wait (sbq.size() == 0);
    run(2, 3);
    report();
  end

endmodule